// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a recovery watchdog for a small 8-bit controller. It leaves reset switched off and stays silent until software writes a fixed two-byte key to one service address on the special-register write bus. From then on it advances a counter once per machine cycle. Software must repeat the same key often enough to clear that counter. If it fails to, the counter runs out and the block raises a reset request for a fixed number of oscillator clocks. That request also returns the watchdog to its off state.

Software has no way to switch the watchdog off again. Only the hardware reset input or the watchdog's own timeout does that. Counting follows the power state of the controller. In power-down the count is frozen. After a power-down exit through an external interrupt, the count stays frozen until the interrupt line has gone high again. In idle, a configuration bit chooses between counting on and pausing. The machine-cycle rate reaches the block as a one-clock enable from a divider outside it. The count cannot be read or written through the bus.

Top module: `seqwd_top`

## Requirements
- R1: After hardware reset (`rst_ni` low, asynchronous) the watchdog is disarmed with a zero count, `armed_o` is 0 and `wd_rst_o` is 0. While disarmed, no number of machine cycles raises `wd_rst_o`.
- R2: A write of 0x1E followed by a write of 0xE1 to service address 0xA6 arms the watchdog. `armed_o` reads 1 from the clock after the edge that takes the 0xE1 write.
- R3: While armed, each clock with `mcyc_tick_i` high and no freeze condition adds one to the count. The timeout happens on the counted tick that would bring the count to 2^CNT_W-1, which is the (2^CNT_W-1)-th counted tick after the last clear. With the default CNT_W=14 that is 16383 ticks.
- R4: The same key pair written while armed clears the count. When the 0xE1 write lands on the same clock as the tick that would time out, the clear wins and no timeout happens.
- R5: A byte other than 0xE1 written to 0xA6 right after 0x1E cancels the pending key and leaves the count alone. A lone 0xE1 does nothing. A repeated 0x1E starts the key again. Writes to other addresses neither advance nor cancel a pending key.
- R6: Once armed, the watchdog stays armed through any bus writes. It only disarms through hardware reset or through its own timeout.
- R7: On timeout, `wd_rst_o` is high for exactly PULSE_LEN clocks (98 by default), starting on the clock after the timeout edge. The same timeout also disarms the watchdog and zeroes the count. Outside such a pulse, `wd_rst_o` is low.
- R8: While `pdown_i` is 1 the count holds. After `pdown_i` falls, the count keeps holding while `wake_lvl_i` is 0. It resumes from the held value once `wake_lvl_i` is 1.
- R9: In idle (`idle_i`=1), with `idle_hold_i`=0 the count runs. With `idle_hold_i`=1 it holds and then continues from the held value when idle ends.
- R10: On clocks with `mcyc_tick_i` low the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| mcyc_tick_i | input | 1 | One-clock enable, once per machine cycle |
| svc_wr_i | input | 1 | Special-register write strobe |
| svc_addr_i | input | ADDR_W | Special-register write address |
| svc_data_i | input | DATA_W | Special-register write data |
| idle_i | input | 1 | Controller is in idle |
| pdown_i | input | 1 | Controller is in power-down |
| wake_lvl_i | input | 1 | External wake interrupt line, low while held |
| idle_hold_i | input | 1 | 1 pauses counting during idle |
| wd_rst_o | output | 1 | Timeout reset pulse, active high |
| armed_o | output | 1 | Watchdog is armed |

## Verification
The bench builds the block with CNT_W=6 and the default PULSE_LEN=98. A timeout then comes after 63 counted ticks instead of 16383. With ticks driven on every clock, every path to a timeout fits in a short run: the plain expiry, the clear-versus-timeout collision, and the resume after power-down, wake hold and idle pause. Keeping the full 98-clock pulse means its length is checked at its real value. It also lets a re-armed counter time out again while a pulse is still running.

// File: rtl/seqwd_pkg.sv
package seqwd_pkg;

  typedef enum logic {
    KEY_WAIT  = 1'b0,
    KEY_HALF  = 1'b1
  } key_state_e;

  localparam logic [7:0] SVC_ADDR_DEF = 8'hA6;
  localparam logic [7:0] KEY_OPEN_DEF = 8'h1E;
  localparam logic [7:0] KEY_SHUT_DEF = 8'hE1;

endpackage

// File: rtl/seqwd_keyseq.sv
module seqwd_keyseq
  import seqwd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(SVC_ADDR_DEF),
  parameter logic [DATA_W-1:0] KEY_OPEN = DATA_W'(KEY_OPEN_DEF),
  parameter logic [DATA_W-1:0] KEY_SHUT = DATA_W'(KEY_SHUT_DEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              key_ok_o
);

  key_state_e st_q;
  logic       hit;

  // a write counts only when it targets the service address
  assign hit      = wr_i && (addr_i == SVC_ADDR);
  assign key_ok_o = hit && (st_q == KEY_HALF) && (data_i == KEY_SHUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= KEY_WAIT;
    end else if (hit) begin
      // any service write either opens a new key or ends the pending one
      st_q <= (data_i == KEY_OPEN) ? KEY_HALF : KEY_WAIT;
    end
  end

endmodule

// File: rtl/seqwd_gate.sv
module seqwd_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic armed_i,
  input  logic pdown_i,
  input  logic idle_i,
  input  logic idle_hold_i,
  input  logic wake_lvl_i,
  output logic wake_wait_o,
  output logic cnt_en_o
);

  logic wake_wait_q;

  function automatic logic may_run(input logic pd, input logic wwait,
                                   input logic wake, input logic idl,
                                   input logic hold);
    return !pd && !(wwait && !wake) && !(idl && hold);
  endfunction

  // set during power-down; released only once the wake line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_wait_q <= 1'b0;
    end else if (pdown_i) begin
      wake_wait_q <= 1'b1;
    end else if (wake_lvl_i) begin
      wake_wait_q <= 1'b0;
    end
  end

  assign wake_wait_o = wake_wait_q;
  assign cnt_en_o    = armed_i && tick_i &&
                       may_run(pdown_i, wake_wait_q, wake_lvl_i, idle_i, idle_hold_i);

endmodule

// File: rtl/seqwd_count.sv
module seqwd_count #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] LAST_SAFE = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic reaches_top(input logic [CNT_W-1:0] c);
    return c == LAST_SAFE;
  endfunction

  // a clear in the same clock beats the timeout
  assign ovf_o = cnt_en_i && !clear_i && reaches_top(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (ovf_o) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en_i) begin
      cnt_q   <= bump(cnt_q);
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/seqwd_pulse.sv
module seqwd_pulse #(
  parameter int unsigned PULSE_LEN = 98,
  localparam int unsigned PW = $clog2(PULSE_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  output logic [PW-1:0] left_o,
  output logic          active_o
);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (fire_i) begin
      left_q <= PW'(PULSE_LEN);
    end else if (left_q != '0) begin
      left_q <= left_q - PW'(1);
    end
  end

  assign left_o   = left_q;
  assign active_o = (left_q != '0);

endmodule

// File: rtl/seqwd_top.sv
module seqwd_top
  import seqwd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned PULSE_LEN = 98,
  parameter logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(SVC_ADDR_DEF),
  parameter logic [DATA_W-1:0] KEY_OPEN = DATA_W'(KEY_OPEN_DEF),
  parameter logic [DATA_W-1:0] KEY_SHUT = DATA_W'(KEY_SHUT_DEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mcyc_tick_i,
  input  logic              svc_wr_i,
  input  logic [ADDR_W-1:0] svc_addr_i,
  input  logic [DATA_W-1:0] svc_data_i,
  input  logic              idle_i,
  input  logic              pdown_i,
  input  logic              wake_lvl_i,
  input  logic              idle_hold_i,
  output logic              wd_rst_o,
  output logic              armed_o
);

  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  // named internal events, observed by the bound checker
  logic             key_ok;
  logic             cnt_en;
  logic             ovf_evt;
  logic             wake_wait;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pulse_left;
  logic             armed;

  seqwd_keyseq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SVC_ADDR(SVC_ADDR), .KEY_OPEN(KEY_OPEN), .KEY_SHUT(KEY_SHUT)
  ) u_key (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(svc_wr_i), .addr_i(svc_addr_i), .data_i(svc_data_i),
    .key_ok_o(key_ok)
  );

  seqwd_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_i(mcyc_tick_i), .armed_i(armed),
    .pdown_i(pdown_i), .idle_i(idle_i), .idle_hold_i(idle_hold_i),
    .wake_lvl_i(wake_lvl_i),
    .wake_wait_o(wake_wait), .cnt_en_o(cnt_en)
  );

  seqwd_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cnt_en_i(cnt_en), .clear_i(key_ok),
    .cnt_o(cnt_q), .armed_o(armed), .ovf_o(ovf_evt)
  );

  seqwd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fire_i(ovf_evt),
    .left_o(pulse_left), .active_o(wd_rst_o)
  );

  assign armed_o = armed;

endmodule

// File: rtl/seqwd_chk.sv
module seqwd_chk #(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned PULSE_LEN = 98,
  localparam int unsigned PW = $clog2(PULSE_LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mcyc_tick_i,
  input logic             idle_i,
  input logic             idle_hold_i,
  input logic             pdown_i,
  input logic             key_ok,
  input logic             ovf_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PW-1:0]    pulse_left,
  input logic             armed_o,
  input logic             wd_rst_o
);

  a_r1_off_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_o |-> cnt_q == '0);

  a_r2_key_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ok |=> armed_o);

  a_r4_key_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ok |=> cnt_q == '0);

  a_r4_key_beats_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ok |-> !ovf_evt);

  a_r6_stays_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && !ovf_evt |=> armed_o);

  a_r7_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> wd_rst_o && !armed_o && pulse_left == PW'(PULSE_LEN));

  a_r7_pulse_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_left == PW'(1) && !ovf_evt |=> !wd_rst_o);

  a_r8_pdown_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_i && !key_ok |=> $stable(cnt_q));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i && idle_hold_i && !key_ok |=> $stable(cnt_q));

  a_r10_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mcyc_tick_i && !key_ok |=> $stable(cnt_q));

endmodule

bind seqwd_top seqwd_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mcyc_tick_i(mcyc_tick_i),
  .idle_i(idle_i), .idle_hold_i(idle_hold_i), .pdown_i(pdown_i),
  .key_ok(key_ok), .ovf_evt(ovf_evt), .cnt_q(cnt_q),
  .pulse_left(pulse_left), .armed_o(armed_o), .wd_rst_o(wd_rst_o)
);

// File: tb/seqwd_top_tb_top.sv
`timescale 1ns/1ps
module seqwd_top_tb_top;

  localparam int W    = 6;
  localparam int PL   = 98;
  localparam int FULL = (1 << W) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] data = 8'h00;
  logic       idle = 1'b0;
  logic       pdown = 1'b0;
  logic       wake = 1'b1;
  logic       hold = 1'b0;
  logic       wd_rst;
  logic       armed;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  seqwd_top #(.CNT_W(W), .PULSE_LEN(PL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mcyc_tick_i(tick),
    .svc_wr_i(wr), .svc_addr_i(addr), .svc_data_i(data),
    .idle_i(idle), .pdown_i(pdown), .wake_lvl_i(wake), .idle_hold_i(hold),
    .wd_rst_o(wd_rst), .armed_o(armed)
  );

  // behavioural expectation built from the requirement text
  bit m_armed, m_half, m_wwait;
  int m_cnt, m_left;

  function automatic bit frozen(bit pd, bit ww, bit wk, bit idl, bit hd);
    if (pd) return 1'b1;
    if (ww && !wk) return 1'b1;
    if (idl && hd) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_half = 0; m_wwait = 0; m_cnt = 0; m_left = 0;
    end else begin
      bit svc, unlock, run;
      svc    = wr && addr == 8'hA6;
      unlock = svc && m_half && data == 8'hE1;
      run    = m_armed && tick && !frozen(pdown, m_wwait, wake, idle, hold);
      if (m_left > 0) m_left = m_left - 1;
      if (unlock) begin
        m_cnt = 0; m_armed = 1;
      end else if (run) begin
        if (m_cnt + 1 == FULL) begin
          m_cnt = 0; m_armed = 0; m_left = PL;
        end else m_cnt = m_cnt + 1;
      end
      if (svc) m_half = (data == 8'h1E);
      if (pdown) m_wwait = 1; else if (wake) m_wwait = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(wd_rst == (m_left != 0), "R7 wd_rst_o per-cycle", int'(wd_rst), int'(m_left != 0));
    chk(armed == m_armed, "R6 armed_o per-cycle", int'(armed), int'(m_armed));
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    wr = 1; addr = a; data = d;
    step();
    wr = 0;
  endtask

  task automatic arm();
    tick = 0;
    wr_byte(8'hA6, 8'h1E);
    wr_byte(8'hA6, 8'hE1);
  endtask

  task automatic wait_fire(output int n);
    n = 0;
    while (!wd_rst && n < 400) begin step(); n++; end
  endtask

  task automatic pulse_width(output int n);
    n = 0;
    while (wd_rst && n < 400) begin n++; step(); end
  endtask

  task automatic quiet(input int cyc, input string tag);
    bit seen = 0;
    repeat (cyc) begin step(); if (wd_rst) seen = 1; end
    chk(!seen, tag, int'(seen), 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk(armed == 0, "R1 armed after reset", int'(armed), 0);
    chk(wd_rst == 0, "R1 wd_rst_o after reset", int'(wd_rst), 0);
    tick = 1;
    quiet(200, "R1 no timeout while disarmed");

    tick = 0;
    wr_byte(8'hA6, 8'hE1);
    chk(armed == 0, "R5 lone second key", int'(armed), 0);
    wr_byte(8'hA6, 8'h1E); wr_byte(8'hA6, 8'h55); wr_byte(8'hA6, 8'hE1);
    chk(armed == 0, "R5 broken key", int'(armed), 0);
    wr_byte(8'hA6, 8'h1E); wr_byte(8'h10, 8'h00); wr_byte(8'hA6, 8'hE1);
    chk(armed == 1, "R5 other address ignored", int'(armed), 1);

    rst_n = 0; step(); rst_n = 1; step();
    chk(armed == 0, "R6 hardware reset disarms", int'(armed), 0);
    wr_byte(8'hA6, 8'h1E); wr_byte(8'hA6, 8'h1E); wr_byte(8'hA6, 8'hE1);
    chk(armed == 1, "R2 armed next clock", int'(armed), 1);

    tick = 1;
    wait_fire(n);
    chk(n == FULL, "R3 ticks to timeout", n, FULL);
    chk(armed == 0, "R7 timeout disarms", int'(armed), 0);
    tick = 0;
    pulse_width(n);
    chk(n == PL, "R7 pulse width", n, PL);

    arm(); tick = 1; repeat (40) step();
    arm(); tick = 1;
    wait_fire(n);
    chk(n == FULL, "R4 service clears count", n, FULL);
    tick = 0; pulse_width(n);

    arm(); tick = 1; repeat (FULL - 1) step();
    tick = 0; wr_byte(8'hA6, 8'h1E);
    tick = 1; wr_byte(8'hA6, 8'hE1);
    chk(wd_rst == 0 && armed == 1, "R4 clear beats timeout", int'(wd_rst), 0);
    wait_fire(n);
    chk(n == FULL, "R4 count restarted", n, FULL);
    tick = 0; pulse_width(n);

    arm();
    for (int i = 0; i < 60; i++) begin
      logic [7:0] d = 8'($urandom);
      if (d == 8'h1E) d = 8'h1F;
      wr_byte(8'($urandom), 8'h00);
      wr_byte(8'hA6, d);
    end
    chk(armed == 1, "R6 writes cannot disarm", int'(armed), 1);

    arm(); tick = 1; repeat (20) step();
    pdown = 1; wake = 0;
    quiet(200, "R8 frozen in power-down");
    pdown = 0;
    quiet(100, "R8 held while wake line low");
    wake = 1;
    wait_fire(n);
    chk(n == FULL - 20, "R8 resumes from held count", n, FULL - 20);
    tick = 0; pulse_width(n);

    arm(); tick = 1; repeat (20) step();
    idle = 1; hold = 1;
    quiet(200, "R9 paused in idle");
    idle = 0;
    wait_fire(n);
    chk(n == FULL - 20, "R9 resumes after idle", n, FULL - 20);
    tick = 0; pulse_width(n);
    arm(); tick = 1; idle = 1; hold = 0;
    wait_fire(n);
    chk(n == FULL, "R9 counts in idle when not paused", n, FULL);
    idle = 0; tick = 0; pulse_width(n);

    arm(); tick = 0;
    quiet(300, "R10 no tick, no count");
    for (int i = 0; i < 3 * FULL + 3; i++) begin
      tick = (i % 3 == 2);
      step();
    end
    chk(m_left != 0 || wd_rst == 1 || armed == 0, "R10 timeout after spaced ticks", int'(armed), 0);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      wr = 0;
      if (r < 25) begin
        int k = $urandom % 3;
        wr = 1; addr = 8'hA6;
        data = (k == 0) ? 8'h1E : (k == 1) ? 8'hE1 : 8'($urandom);
      end else if (r < 30) begin
        wr = 1; addr = 8'($urandom); data = 8'($urandom);
      end
      tick  = ($urandom % 4) != 0;
      idle  = ($urandom % 8) == 0;
      hold  = $urandom % 2;
      pdown = ($urandom % 40) == 0;
      wake  = ($urandom % 3) != 0;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule